// File: doc/BRIEF.md
# Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a small direct-mapped table, arranged like a cache, in which every entry has a valid flag, an address tag and a history field. Each lookup presents a branch address and the sign of its displacement. One cycle later the block returns a taken or not-taken guess, together with a flag that says whether the guess came from the table.

When the table has no matching entry, the block uses a fixed rule: a branch that jumps backward is guessed taken, and a branch that jumps forward is guessed not taken. When a branch resolves, its actual outcome is written into the table. This either refreshes the matching entry or replaces whatever occupied the slot. A parameter chooses between a one-bit history (repeat the last outcome) and a two-bit saturating counter.

The index is taken from address bits [IDX_W+1:2], which are bits [7:2] at the default of 64 entries. The tag is made of all the address bits above the index. Address bits [1:0] play no part.

Top module: `bp_dir_predictor`

## Requirements
- R1: After reset every table entry is invalid, so each lookup reports pred_hit = 0 until a resolve has written the matching entry, and pred_valid is 0 while no lookup is in flight.
- R2: A lookup that misses the table predicts taken when lk_disp is negative (most significant bit = 1) and not taken otherwise, and reports pred_hit = 0.
- R3: pred_valid is 1 exactly in the cycle after a cycle with lk_valid = 1. Back-to-back lookups give back-to-back results in request order.
- R4: With HIST_W = 1, a lookup that hits predicts the outcome of the most recent resolve of that branch, whatever the displacement sign.
- R5: With HIST_W = 2, a resolve that misses allocates the entry with the counter set to 2'b10 if taken and 2'b01 if not taken. A later hit then predicts that same outcome.
- R6: With HIST_W = 2, a resolve that hits increments the counter if taken and decrements it if not taken, saturating at 2'b11 and 2'b00. The prediction is counter bit 1.
- R7: Entries are matched by tag. A branch whose address shares the index but not the tag misses and uses the static rule. A resolve of that branch replaces the entry, after which the previous branch misses.
- R8: When a lookup and a resolve address the same entry in one cycle, the lookup result reflects the entry as it was before that resolve.
- R9: The index is address bits [IDX_W+1:2] and the tag is bits [ADDR_W-1:IDX_W+2]. Address bits [1:0] do not affect hit or prediction, and addresses differing only in bit 2 use different entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | ADDR_W | Address of the branch being looked up |
| lk_disp | input | DISP_W | Signed branch displacement of the looked-up branch |
| rs_valid | input | 1 | Resolve (update) this cycle |
| rs_addr | input | ADDR_W | Address of the resolved branch |
| rs_taken | input | 1 | Actual outcome of the resolved branch |
| pred_valid | output | 1 | Prediction result present |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hit | output | 1 | Prediction came from a matching table entry |

## Verification
The hardest case to reach is the two-bit counter at the edge of its range, because saturation only shows up after a chosen run of outcomes on one branch. It is also the only case in which the two history modes disagree about the same branch. The stimulus drives several same-branch resolves in a row and runs a one-bit and a two-bit instance side by side, so every lookup compares both modes. The same-cycle lookup/resolve race and the tag conflict are each set up with a dedicated helper that aims two addresses at one index.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // Next history value for a resolve; one-bit history uses bit 0 only.
  function automatic logic [1:0] hist_next(input logic [1:0] cur,
                                           input logic       hit,
                                           input logic       taken,
                                           input logic       two_bit);
    if (!two_bit) return {1'b0, taken};
    if (!hit)     return taken ? 2'b10 : 2'b01;
    if (taken)    return (cur == 2'b11) ? 2'b11 : cur + 2'd1;
    return (cur == 2'b00) ? 2'b00 : cur - 2'd1;
  endfunction

  // Direction encoded by a history value.
  function automatic logic hist_predict(input logic [1:0] h, input logic two_bit);
    return two_bit ? h[1] : h[0];
  endfunction

  // Static fallback: backward (negative) displacement means taken.
  function automatic logic static_guess(input logic disp_sign);
    return disp_sign;
  endfunction

endpackage

// File: rtl/bp_hist_update.sv
module bp_hist_update #(
  parameter int HIST_W = 2
) (
  input  logic [HIST_W-1:0] cur,
  input  logic              hit,
  input  logic              taken,
  output logic [HIST_W-1:0] nxt
);
  import bp_pkg::*;

  localparam logic TWO = (HIST_W == 2);

  logic [1:0] cur_ext;
  logic [1:0] nxt_ext;

  always_comb begin
    cur_ext = 2'b00;
    cur_ext[HIST_W-1:0] = cur;
    nxt_ext = hist_next(cur_ext, hit, taken, TWO);
  end

  assign nxt = nxt_ext[HIST_W-1:0];

endmodule

// File: rtl/bp_table.sv
module bp_table #(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 24,
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic              ra_vld,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [HIST_W-1:0] ra_hist,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic              rb_vld,
  output logic [TAG_W-1:0]  rb_tag,
  output logic [HIST_W-1:0] rb_hist,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [HIST_W-1:0] wr_hist
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] vld;
  logic [TAG_W-1:0]   tag_mem  [ENTRIES];
  logic [HIST_W-1:0]  hist_mem [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (!rst_n) vld[e] <= 1'b0;
      else if (sel) vld[e] <= 1'b1;
      if (sel) begin
        tag_mem[e]  <= wr_tag;
        hist_mem[e] <= wr_hist;
      end
    end
  end

  assign ra_vld  = vld[ra_idx];
  assign ra_tag  = tag_mem[ra_idx];
  assign ra_hist = hist_mem[ra_idx];
  assign rb_vld  = vld[rb_idx];
  assign rb_tag  = tag_mem[rb_idx];
  assign rb_hist = hist_mem[rb_idx];

  // Observation wires for the checks below.
  logic              wr_match;
  logic [HIST_W-1:0] wr_prev_hist;
  assign wr_match     = vld[wr_idx] && (tag_mem[wr_idx] == wr_tag);
  assign wr_prev_hist = hist_mem[wr_idx];

  // R7: a written slot is valid and holds the written tag afterwards.
  a_r7_slot_owned: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld[$past(wr_idx)] && (tag_mem[$past(wr_idx)] == $past(wr_tag)));

  if (HIST_W == 2) begin : g_step_chk
    // R6: a hit update moves the counter by at most one step, never wrapping.
    a_r6_one_step: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_match |=>
        (hist_mem[$past(wr_idx)] == $past(wr_prev_hist)) ||
        (($past(wr_prev_hist) != 2'b11) && (hist_mem[$past(wr_idx)] == $past(wr_prev_hist) + 2'd1)) ||
        (($past(wr_prev_hist) != 2'b00) && (hist_mem[$past(wr_idx)] == $past(wr_prev_hist) - 2'd1)));
  end

endmodule

// File: rtl/bp_dir_predictor.sv
module bp_dir_predictor #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int HIST_W = 2,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [DISP_W-1:0] lk_disp,
  input  logic              rs_valid,
  input  logic [ADDR_W-1:0] rs_addr,
  input  logic              rs_taken,
  output logic              pred_valid,
  output logic              pred_taken,
  output logic              pred_hit
);
  import bp_pkg::*;

  localparam int   TAG_W = ADDR_W - IDX_W - 2;
  localparam logic TWO   = (HIST_W == 2);

  logic [IDX_W-1:0]  lk_idx, rs_idx;
  logic [TAG_W-1:0]  lk_tag, rs_tag;
  logic              la_vld, rb_vld;
  logic [TAG_W-1:0]  la_tag, rb_tag;
  logic [HIST_W-1:0] la_hist, rb_hist, upd_hist;
  logic              lk_hit, rs_hit;
  logic              hist_dir, guess_dir, lk_dir;

  assign lk_idx = lk_addr[IDX_W+1:2];
  assign lk_tag = lk_addr[ADDR_W-1:IDX_W+2];
  assign rs_idx = rs_addr[IDX_W+1:2];
  assign rs_tag = rs_addr[ADDR_W-1:IDX_W+2];

  bp_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .HIST_W(HIST_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .ra_idx  (lk_idx),
    .ra_vld  (la_vld),
    .ra_tag  (la_tag),
    .ra_hist (la_hist),
    .rb_idx  (rs_idx),
    .rb_vld  (rb_vld),
    .rb_tag  (rb_tag),
    .rb_hist (rb_hist),
    .wr_en   (rs_valid),
    .wr_idx  (rs_idx),
    .wr_tag  (rs_tag),
    .wr_hist (upd_hist)
  );

  assign lk_hit = la_vld && (la_tag == lk_tag);
  assign rs_hit = rb_vld && (rb_tag == rs_tag);

  bp_hist_update #(.HIST_W(HIST_W)) u_update (
    .cur   (rb_hist),
    .hit   (rs_hit),
    .taken (rs_taken),
    .nxt   (upd_hist)
  );

  always_comb begin
    logic [1:0] h_ext;
    h_ext = 2'b00;
    h_ext[HIST_W-1:0] = la_hist;
    hist_dir  = hist_predict(h_ext, TWO);
    guess_dir = static_guess(lk_disp[DISP_W-1]);
    lk_dir    = lk_hit ? hist_dir : guess_dir;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_valid <= 1'b0;
      pred_taken <= 1'b0;
      pred_hit   <= 1'b0;
    end else begin
      pred_valid <= lk_valid;
      pred_taken <= lk_valid && lk_dir;
      pred_hit   <= lk_valid && lk_hit;
    end
  end

  // R3: a result follows each lookup by exactly one cycle.
  a_r3_result_timing: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> pred_valid);
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !pred_valid);

  // R2: a miss on a backward branch comes back as taken.
  a_r2_static_rule: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !lk_hit |=> !pred_hit && (pred_taken == $past(lk_disp[DISP_W-1])));

  if (HIST_W == 1) begin : g_one_chk
    // R4: the outcome just resolved is repeated on the next lookup of that branch.
    a_r4_repeat_last: assert property (@(posedge clk) disable iff (!rst_n)
      rs_valid ##1 (lk_valid && !rs_valid && lk_addr == $past(rs_addr)) |=>
        pred_hit && (pred_taken == $past(rs_taken, 2)));
  end else begin : g_two_chk
    // R5: a freshly allocated counter predicts the allocating outcome.
    a_r5_alloc_dir: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid && !rs_hit) ##1 (lk_valid && !rs_valid && lk_addr == $past(rs_addr)) |=>
        pred_hit && (pred_taken == $past(rs_taken, 2)));
  end

endmodule

// File: tb/tb_bp_dir_predictor.sv
`timescale 1ns/1ps
module tb_bp_dir_predictor;

  localparam int ADDR_W = 32;
  localparam int DISP_W = 16;
  localparam logic [DISP_W-1:0] BACK = 16'hFFF0;
  localparam logic [DISP_W-1:0] FWD  = 16'h0010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0;
  logic [ADDR_W-1:0] lk_addr = '0;
  logic [DISP_W-1:0] lk_disp = '0;
  logic rs_valid = 1'b0;
  logic [ADDR_W-1:0] rs_addr = '0;
  logic rs_taken = 1'b0;
  logic pv2, pt2, ph2, pv1, pt1, ph1;

  always #4 clk = ~clk;

  bp_dir_predictor #(.HIST_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_disp(lk_disp),
    .rs_valid(rs_valid), .rs_addr(rs_addr), .rs_taken(rs_taken),
    .pred_valid(pv2), .pred_taken(pt2), .pred_hit(ph2));

  bp_dir_predictor #(.HIST_W(1)) dut1 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_disp(lk_disp),
    .rs_valid(rs_valid), .rs_addr(rs_addr), .rs_taken(rs_taken),
    .pred_valid(pv1), .pred_taken(pt1), .pred_hit(ph1));

  typedef struct {
    string req;
    bit    h2, t2, h1, t1;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per result.
  always @(negedge clk) begin
    if (rst_n) begin
      check("R3", "modes agree on pred_valid", pv1, pv2);
      if (pv2) begin
        if (sb.size() == 0) begin
          check("R3", "result without request", 1'b1, 1'b0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.req, "2-bit hit",   ph2, e.h2);
          check(e.req, "2-bit taken", pt2, e.t2);
          check(e.req, "1-bit hit",   ph1, e.h1);
          check(e.req, "1-bit taken", pt1, e.t1);
        end
      end
    end
  end

  // Drivers: called at a falling edge, return at the next one.
  task automatic lookup(input string req, input logic [ADDR_W-1:0] a, input logic [DISP_W-1:0] d,
                        input bit h2, input bit t2, input bit h1, input bit t1);
    exp_t e;
    e.req = req; e.h2 = h2; e.t2 = t2; e.h1 = h1; e.t1 = t1;
    sb.push_back(e);
    lk_valid = 1'b1; lk_addr = a; lk_disp = d;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic resolve(input logic [ADDR_W-1:0] a, input logic tk);
    rs_valid = 1'b1; rs_addr = a; rs_taken = tk;
    @(negedge clk);
    rs_valid = 1'b0;
  endtask

  task automatic both(input string req, input logic [ADDR_W-1:0] a, input logic tk,
                      input logic [DISP_W-1:0] d, input bit h2, input bit t2, input bit h1, input bit t1);
    rs_valid = 1'b1; rs_addr = a; rs_taken = tk;
    lookup(req, a, d, h2, t2, h1, t1);
    rs_valid = 1'b0;
  endtask

  localparam logic [ADDR_W-1:0] A = 32'h0000_1040;  // index 0x10
  localparam logic [ADDR_W-1:0] B = 32'h0000_1140;  // same index, other tag
  localparam logic [ADDR_W-1:0] C = 32'h0000_1144;  // neighbour index

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "pred_valid in reset", pv2, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "pred_valid idle", pv2, 1'b0);

    // R1/R2: empty table, static rule
    lookup("R2", A, BACK, 0, 1, 0, 1);
    lookup("R2", A, FWD,  0, 0, 0, 0);

    // R5/R4: allocate taken, forward branch now predicted from history
    resolve(A, 1'b1);
    lookup("R5", A, FWD, 1, 1, 1, 1);

    // R6: 10->11, then 11->10 still taken; one-bit follows last outcome
    resolve(A, 1'b1);
    resolve(A, 1'b0);
    lookup("R6", A, BACK, 1, 1, 1, 0);
    resolve(A, 1'b0);   // 2-bit: 01
    lookup("R6", A, BACK, 1, 0, 1, 0);
    resolve(A, 1'b0);   // 00
    resolve(A, 1'b0);   // stays 00
    resolve(A, 1'b1);   // 01, one-bit: taken
    lookup("R4", A, BACK, 1, 0, 1, 1);
    resolve(A, 1'b1);   // 10
    lookup("R6", A, FWD, 1, 1, 1, 1);

    // R7: conflicting tag at the same index
    lookup("R7", B, BACK, 0, 1, 0, 1);
    resolve(B, 1'b0);
    lookup("R7", A, BACK, 0, 1, 0, 1);
    lookup("R7", B, BACK, 1, 0, 1, 0);

    // R9: low two bits ignored, bit 2 selects another entry
    lookup("R9", B + 32'd3, BACK, 1, 0, 1, 0);
    lookup("R9", C, FWD, 0, 0, 0, 0);

    // R8: same-cycle resolve and lookup see the old entry
    both("R8", C, 1'b1, FWD, 0, 0, 0, 0);
    lookup("R8", C, FWD, 1, 1, 1, 1);
    both("R8", B, 1'b1, FWD, 1, 0, 1, 0);
    lookup("R8", B, FWD, 1, 1, 1, 1);

    // R3: back-to-back lookups in order
    sb.push_back('{req:"R3", h2:1, t2:1, h1:1, t1:1});
    lk_valid = 1'b1; lk_addr = C; lk_disp = FWD;
    @(negedge clk);
    sb.push_back('{req:"R3", h2:0, t2:1, h1:0, t1:1});
    lk_addr = A; lk_disp = BACK;
    @(negedge clk);
    sb.push_back('{req:"R3", h2:0, t2:0, h1:0, t1:0});
    lk_addr = 32'h0000_2000; lk_disp = FWD;
    @(negedge clk);
    lk_valid = 1'b0;
    @(negedge clk);
    check("R3", "pred_valid after last", pv2, 1'b0);
    check("R3", "all results seen", sb.size() == 0, 1'b1);

    // R1: reset clears the table
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    lookup("R1", C, FWD, 0, 0, 0, 0);
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule